// File: doc/BRIEF.md
# System Clock Source Switch with Failover

This block chooses which of four oscillators drives the system clock: internal high-speed, external high-speed, internal low-speed and external low-speed. Each oscillator appears as a ready level and, for the external high-speed one, a clock-enable pulse stream in a single reference clock domain. Software writes a 3-bit requested source and reads back both that request and a separate 3-bit status that names the source actually in use. A change of source takes effect only once the target oscillator is both enabled and ready. Until then the previous source remains active.

Hardware can override software in several ways. Leaving a low-power mode returns both the request and the status to the internal high-speed source. A clock monitor watches the external high-speed oscillator. If the edges from that oscillator stop, the monitor flags a failure, switches itself off and moves the system back to the internal high-speed source. Oscillator enable bits are protected. An enable cannot be cleared while its oscillator is in use. The internal high-speed enable follows hardware first: it is forced on while that source runs the system and forced off during low-power mode.

Top module: `sysclk_source_switch`

## Requirements
- R1: The source code is 0 = internal high-speed, 1 = external high-speed, 3 = internal low-speed, 4 = external low-speed. A write of any other code leaves `sel_q` unchanged.
- R2: Out of reset, `sel_q` = 0, `src_status` = 0, `osc_en` = 4'b0001, and `css_on` and `fail_flag` are 0. `src_status` uses the R1 codes. `osc_en`/`osc_rdy` bit 0 = internal high-speed, bit 1 = external high-speed, bit 2 = internal low-speed, bit 3 = external low-speed.
- R3: When `sel_q` differs from `src_status`, `src_status` takes the requested code one cycle after the target's enable and ready bits are both 1. Before that it keeps its old value.
- R4: The cycle after `lp_mode` falls, `sel_q` and `src_status` are both 0 and `osc_en[0]` is 1.
- R5: A software write cannot clear the enable bit of the oscillator in use. On entry to low-power mode (a rise of `lp_mode`), `osc_en[1]` is cleared.
- R6: While `lp_mode` is 1, `osc_en[0]` is 0. Otherwise `osc_en[0]` is 1 whenever the internal high-speed source is in use, including after a failover.
- R7: The monitor runs only while `css_on` and `osc_rdy[1]` are both 1. It declares a failure after TIMEOUT consecutive running cycles with no `ehs_tick`. When it is not running, the count restarts.
- R8: A failure clears `css_on` and sets `fail_flag` on the next cycle. It also forces `sel_q` to 0 if `sel_q` was 1, and forces `src_status` to 0 if `src_status` was 1.
- R9: A `fail_clr` pulse clears `fail_flag`. A failure in the same cycle takes priority, so the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_rdy | input | 4 | Oscillator ready levels, one bit per oscillator |
| ehs_tick | input | 1 | Clock-enable pulse from the external high-speed oscillator |
| lp_mode | input | 1 | Device is in a low-power mode |
| sel_wr | input | 1 | Write strobe for the requested source |
| sel_wdata | input | 3 | Requested source code |
| en_wr | input | 1 | Write strobe for the oscillator enables |
| en_wdata | input | 4 | Enable values written by software |
| css_wr | input | 1 | Write strobe for the monitor enable |
| css_wdata | input | 1 | Monitor enable value |
| fail_clr | input | 1 | Write-one pulse that clears the failure flag |
| sel_q | output | 3 | Requested source as read back |
| src_status | output | 3 | Source actually driving the system clock |
| osc_en | output | 4 | Effective oscillator enables |
| css_on | output | 1 | Monitor enable |
| fail_flag | output | 1 | Pending failure interrupt flag |

## Verification
The hardest case to reach is a failure that lands in exactly the same cycle as a flag clear. The detector fires only after an exact count of silent cycles, and only with the flag already set from an earlier failure. The stimulus leaves the first failure uncleared and re-arms the monitor with the external oscillator ready and no pulses. It then counts reference cycles from the arming write and issues `fail_clr` on the cycle in which the count expires. The bench model checks every cycle that the flag stays set. A second hard case is entering low-power mode while running from a low-speed source with the external high-speed enable set. That shows the hardware clear and the hold-low of the internal enable in a single step.

// File: rtl/sysclk_sw_pkg.sv
// Package: source codes and index mapping shared by the clock switch.
// Assumes four oscillators, indexed 0..3 in the order internal-hs,
// external-hs, internal-ls, external-ls.
package sysclk_sw_pkg;
    localparam int NUM_OSC = 4;
    localparam int CODE_W  = 3;
    localparam int IDX_W   = $clog2(NUM_OSC);

    localparam logic [CODE_W-1:0] SRC_IHS = 3'd0;
    localparam logic [CODE_W-1:0] SRC_EHS = 3'd1;
    localparam logic [CODE_W-1:0] SRC_ILS = 3'd3;
    localparam logic [CODE_W-1:0] SRC_ELS = 3'd4;

    // Source code that belongs to an oscillator index.
    function automatic logic [CODE_W-1:0] code_of(input int unsigned idx);
        case (idx)
            0:       return SRC_IHS;
            1:       return SRC_EHS;
            2:       return SRC_ILS;
            default: return SRC_ELS;
        endcase
    endfunction

    // Oscillator index that belongs to a source code.
    function automatic logic [IDX_W-1:0] idx_of(input logic [CODE_W-1:0] c);
        case (c)
            SRC_EHS: return IDX_W'(1);
            SRC_ILS: return IDX_W'(2);
            SRC_ELS: return IDX_W'(3);
            default: return IDX_W'(0);
        endcase
    endfunction

    // True for the four defined codes.
    function automatic logic code_legal(input logic [CODE_W-1:0] c);
        return (c == SRC_IHS) || (c == SRC_EHS) || (c == SRC_ILS) || (c == SRC_ELS);
    endfunction
endpackage

// File: rtl/sysclk_css_mon.sv
// Clock security monitor for the external high-speed oscillator.
// Counts reference cycles without an ehs_tick while armed and the oscillator
// is ready; after TIMEOUT silent cycles it reports a one-cycle failure,
// disarms itself and raises a sticky flag. Assumes TIMEOUT >= 2.
module sysclk_css_mon #(
    parameter int TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ehs_rdy,
    input  logic ehs_tick,
    input  logic css_wr,
    input  logic css_wdata,
    input  logic fail_clr,
    output logic css_on,
    output logic fail_flag,
    output logic fail_det
);
    localparam int CNT_W = $clog2(TIMEOUT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

    logic [CNT_W-1:0] miss_cnt;
    logic             running;

    assign running  = css_on && ehs_rdy;
    assign fail_det = running && !ehs_tick && (miss_cnt == LAST);

    // Purpose: count consecutive silent cycles while the monitor runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            miss_cnt <= '0;
        else if (running && !ehs_tick && !fail_det)
            miss_cnt <= miss_cnt + 1'b1;
        else
            miss_cnt <= '0;
    end

    // Purpose: monitor enable, software written, hardware cleared on failure.
    always_ff @(posedge clk) begin
        if (!rst_n)
            css_on <= 1'b0;
        else if (fail_det)
            css_on <= 1'b0;
        else if (css_wr)
            css_on <= css_wdata;
    end

    // Purpose: sticky failure flag, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fail_flag <= 1'b0;
        else if (fail_det)
            fail_flag <= 1'b1;
        else if (fail_clr)
            fail_flag <= 1'b0;
    end

    AST_FAIL_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        fail_det |=> (!css_on && fail_flag)); // R8
    AST_CLR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_clr && !fail_det) |=> !fail_flag); // R9
    AST_SILENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!css_on || !ehs_rdy) |=> (miss_cnt == '0)); // R7
endmodule

// File: rtl/sysclk_sel_ctrl.sv
// Request and status registers of the clock switch.
// Holds the software request and the source in use. A pending switch
// completes when the target is enabled and ready; low-power exit and
// external failure override it. Also reports low-power entry and exit.
module sysclk_sel_ctrl
    import sysclk_sw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lp_mode,
    input  logic                sel_wr,
    input  logic [CODE_W-1:0]   sel_wdata,
    input  logic                fail_det,
    input  logic [NUM_OSC-1:0]  osc_en,
    input  logic [NUM_OSC-1:0]  osc_rdy,
    output logic [CODE_W-1:0]   sel_q,
    output logic [CODE_W-1:0]   src_q,
    output logic [CODE_W-1:0]   src_nxt,
    output logic                lp_entry
);
    logic              lp_q;
    logic              lp_exit;
    logic [IDX_W-1:0]  tgt_idx;
    logic              tgt_ok;
    logic [CODE_W-1:0] sel_nxt;

    assign lp_exit  = lp_q && !lp_mode;
    assign lp_entry = !lp_q && lp_mode;
    assign tgt_idx  = idx_of(sel_q);
    assign tgt_ok   = osc_en[tgt_idx] && osc_rdy[tgt_idx];

    // Purpose: next request, hardware overrides ahead of software writes.
    always_comb begin
        sel_nxt = sel_q;
        if (lp_exit)
            sel_nxt = SRC_IHS;
        else if (fail_det && sel_q == SRC_EHS)
            sel_nxt = SRC_IHS;
        else if (sel_wr && code_legal(sel_wdata))
            sel_nxt = sel_wdata;
    end

    // Purpose: next source in use, switching only onto a ready target.
    always_comb begin
        src_nxt = src_q;
        if (lp_exit)
            src_nxt = SRC_IHS;
        else if (fail_det && src_q == SRC_EHS)
            src_nxt = SRC_IHS;
        else if (sel_q != src_q && tgt_ok)
            src_nxt = sel_q;
    end

    // Purpose: state registers for request, status and low-power history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SRC_IHS;
            src_q <= SRC_IHS;
            lp_q  <= 1'b0;
        end else begin
            sel_q <= sel_nxt;
            src_q <= src_nxt;
            lp_q  <= lp_mode;
        end
    end

    AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && !code_legal(sel_wdata) && !lp_exit && !fail_det) |=> $stable(sel_q)); // R1
    AST_SWITCH_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != src_q && !tgt_ok && !lp_exit && !fail_det) |=> $stable(src_q)); // R3
    AST_LP_EXIT_IHS: assert property (@(posedge clk) disable iff (!rst_n)
        lp_exit |=> (sel_q == SRC_IHS && src_q == SRC_IHS)); // R4
    AST_FAIL_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_det && sel_q == SRC_EHS && !lp_exit) |=> (sel_q == SRC_IHS)); // R8
endmodule

// File: rtl/sysclk_en_ctrl.sv
// Oscillator enable bits with hardware overrides.
// Software writes all bits at once; the bit of the source in use (next
// state) cannot be cleared. Bit 0 is held high while its oscillator runs
// the system and low in low-power mode; bit 1 is cleared on low-power entry.
module sysclk_en_ctrl
    import sysclk_sw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lp_mode,
    input  logic                lp_entry,
    input  logic                en_wr,
    input  logic [NUM_OSC-1:0]  en_wdata,
    input  logic [CODE_W-1:0]   src_nxt,
    output logic [NUM_OSC-1:0]  osc_en
);
    for (genvar k = 0; k < NUM_OSC; k++) begin : g_osc
        logic in_use;
        assign in_use = (src_nxt == code_of(k));

        if (k == 0) begin : g_ihs
            // Purpose: internal high-speed enable, hardware first.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    osc_en[k] <= 1'b1;
                else if (lp_mode)
                    osc_en[k] <= 1'b0;
                else if (in_use)
                    osc_en[k] <= 1'b1;
                else if (en_wr)
                    osc_en[k] <= en_wdata[k];
            end
        end else if (k == 1) begin : g_ehs
            // Purpose: external high-speed enable, cleared on low-power entry.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    osc_en[k] <= 1'b0;
                else if (lp_entry)
                    osc_en[k] <= 1'b0;
                else if (en_wr)
                    osc_en[k] <= en_wdata[k] || in_use;
            end
        end else begin : g_other
            // Purpose: low-speed enable, locked while in use.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    osc_en[k] <= 1'b0;
                else if (en_wr)
                    osc_en[k] <= en_wdata[k] || in_use;
            end
        end
    end

    AST_EHS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (src_nxt == SRC_EHS && osc_en[1] && !lp_entry) |=> osc_en[1]); // R5
    AST_IHS_LP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        lp_mode |=> !osc_en[0]); // R6
endmodule

// File: rtl/sysclk_source_switch.sv
// Top of the system clock source switch.
// Ties the request/status registers, the enable bits and the external
// high-speed clock monitor together. All inputs are in the reference domain.
module sysclk_source_switch
    import sysclk_sw_pkg::*;
#(
    parameter int TIMEOUT = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   osc_rdy,
    input  logic         ehs_tick,
    input  logic         lp_mode,
    input  logic         sel_wr,
    input  logic [2:0]   sel_wdata,
    input  logic         en_wr,
    input  logic [3:0]   en_wdata,
    input  logic         css_wr,
    input  logic         css_wdata,
    input  logic         fail_clr,
    output logic [2:0]   sel_q,
    output logic [2:0]   src_status,
    output logic [3:0]   osc_en,
    output logic         css_on,
    output logic         fail_flag
);
    logic              fail_det;
    logic              lp_entry;
    logic [CODE_W-1:0] src_nxt;

    sysclk_css_mon #(.TIMEOUT(TIMEOUT)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .ehs_rdy   (osc_rdy[1]),
        .ehs_tick  (ehs_tick),
        .css_wr    (css_wr),
        .css_wdata (css_wdata),
        .fail_clr  (fail_clr),
        .css_on    (css_on),
        .fail_flag (fail_flag),
        .fail_det  (fail_det)
    );

    sysclk_sel_ctrl u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .lp_mode   (lp_mode),
        .sel_wr    (sel_wr),
        .sel_wdata (sel_wdata),
        .fail_det  (fail_det),
        .osc_en    (osc_en),
        .osc_rdy   (osc_rdy),
        .sel_q     (sel_q),
        .src_q     (src_status),
        .src_nxt   (src_nxt),
        .lp_entry  (lp_entry)
    );

    sysclk_en_ctrl u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .lp_mode  (lp_mode),
        .lp_entry (lp_entry),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .src_nxt  (src_nxt),
        .osc_en   (osc_en)
    );
endmodule

// File: tb/sysclk_source_switch_test.sv
module sysclk_source_switch_test;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 8;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] osc_rdy = 4'b0001;
    logic       ehs_tick;
    logic       lp_mode = 1'b0;
    logic       sel_wr = 1'b0;
    logic [2:0] sel_wdata = 3'd0;
    logic       en_wr = 1'b0;
    logic [3:0] en_wdata = 4'd0;
    logic       css_wr = 1'b0;
    logic       css_wdata = 1'b0;
    logic       fail_clr = 1'b0;
    logic [2:0] sel_q, src_status;
    logic [3:0] osc_en;
    logic       css_on, fail_flag;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit tick_on = 1'b0;
    int tick_ph = 0;

    // Reference model state
    int m_sel, m_src, m_cnt;
    logic [3:0] m_en;
    bit m_css, m_flag, m_lpq;

    sysclk_source_switch #(.TIMEOUT(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .osc_rdy(osc_rdy), .ehs_tick(ehs_tick),
        .lp_mode(lp_mode), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .en_wr(en_wr), .en_wdata(en_wdata), .css_wr(css_wr),
        .css_wdata(css_wdata), .fail_clr(fail_clr), .sel_q(sel_q),
        .src_status(src_status), .osc_en(osc_en), .css_on(css_on),
        .fail_flag(fail_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int osc_index(input int code);
        case (code)
            1: return 1;
            3: return 2;
            4: return 3;
            default: return 0;
        endcase
    endfunction

    // External oscillator pulse every third cycle when enabled
    always @(negedge clk) begin
        if (!rst_n) begin
            ehs_tick <= 1'b0;
            tick_ph  <= 0;
        end else begin
            tick_ph  <= (tick_ph == 2) ? 0 : tick_ph + 1;
            ehs_tick <= tick_on && (tick_ph == 0);
        end
    end

    // Behavioural reference model stepping on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_src = 0; m_en = 4'b0001;
            m_css = 0; m_flag = 0; m_cnt = 0; m_lpq = 0;
        end else begin
            bit act, fail, lpx, lpe;
            int nsel, nsrc, t;
            logic [3:0] nen;
            act  = m_css && osc_rdy[1];
            fail = act && !ehs_tick && (m_cnt == TMO - 1);
            lpx  = m_lpq && !lp_mode;
            lpe  = !m_lpq && lp_mode;
            nsel = m_sel;
            if (lpx) nsel = 0;
            else if (fail && m_sel == 1) nsel = 0;
            else if (sel_wr && (sel_wdata inside {3'd0, 3'd1, 3'd3, 3'd4})) nsel = int'(sel_wdata);
            t = osc_index(m_sel);
            nsrc = m_src;
            if (lpx) nsrc = 0;
            else if (fail && m_src == 1) nsrc = 0;
            else if (m_sel != m_src && m_en[t] && osc_rdy[t]) nsrc = m_sel;
            nen = m_en;
            if (lp_mode) nen[0] = 0;
            else if (nsrc == 0) nen[0] = 1;
            else if (en_wr) nen[0] = en_wdata[0];
            if (lpe) nen[1] = 0;
            else if (en_wr) nen[1] = en_wdata[1] || (nsrc == 1);
            if (en_wr) nen[2] = en_wdata[2] || (nsrc == 3);
            if (en_wr) nen[3] = en_wdata[3] || (nsrc == 4);
            m_cnt  = (act && !ehs_tick && !fail) ? m_cnt + 1 : 0;
            m_flag = fail ? 1'b1 : (fail_clr ? 1'b0 : m_flag);
            m_css  = fail ? 1'b0 : (css_wr ? css_wdata : m_css);
            m_sel = nsel; m_src = nsrc; m_en = nen; m_lpq = lp_mode;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare against the model on every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1", "model sel_q", int'(sel_q), m_sel);
            chk("R3", "model src_status", int'(src_status), m_src);
            chk("R5", "model osc_en", int'(osc_en), int'(m_en));
            chk("R7", "model css_on", int'(css_on), int'(m_css));
            chk("R9", "model fail_flag", int'(fail_flag), int'(m_flag));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_sel(input logic [2:0] c);
        sel_wr = 1'b1; sel_wdata = c; step(1); sel_wr = 1'b0;
    endtask

    task automatic wr_en(input logic [3:0] v);
        en_wr = 1'b1; en_wdata = v; step(1); en_wr = 1'b0;
    endtask

    task automatic wr_css(input logic v);
        css_wr = 1'b1; css_wdata = v; step(1); css_wr = 1'b0;
    endtask

    task automatic pulse_clr();
        fail_clr = 1'b1; step(1); fail_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R2 reset state
        chk("R2", "reset sel_q", int'(sel_q), 0);
        chk("R2", "reset src_status", int'(src_status), 0);
        chk("R2", "reset osc_en", int'(osc_en), 1);
        chk("R2", "reset fail_flag", int'(fail_flag), 0);
        // R1 reserved codes ignored
        wr_sel(3'd2);
        chk("R1", "code 2 ignored", int'(sel_q), 0);
        wr_sel(3'd7);
        chk("R1", "code 7 ignored", int'(sel_q), 0);
        // R3 switch waits for enable and ready
        wr_sel(3'd1);
        chk("R1", "code 1 accepted", int'(sel_q), 1);
        step(3);
        chk("R3", "no switch while disabled", int'(src_status), 0);
        wr_en(4'b0011);
        step(3);
        chk("R3", "no switch while not ready", int'(src_status), 0);
        osc_rdy[1] = 1'b1;
        step(2);
        chk("R3", "switched to ext-hs", int'(src_status), 1);
        // R5 in-use enable locked, ihs no longer held
        wr_en(4'b0000);
        chk("R5", "ext-hs enable kept", int'(osc_en), 4'b0010);
        // R7 monitor with regular pulses: no failure
        tick_on = 1'b1;
        wr_css(1'b1);
        step(40);
        chk("R7", "no failure with pulses", int'(fail_flag), 0);
        chk("R7", "monitor still on", int'(css_on), 1);
        // R7 gated when not ready
        tick_on = 1'b0;
        osc_rdy[1] = 1'b0;
        step(20);
        chk("R7", "no failure when not ready", int'(fail_flag), 0);
        // R8 failure and failover
        osc_rdy[1] = 1'b1;
        step(TMO + 2);
        chk("R8", "flag set", int'(fail_flag), 1);
        chk("R8", "monitor off", int'(css_on), 0);
        chk("R8", "sel forced", int'(sel_q), 0);
        chk("R8", "status forced", int'(src_status), 0);
        chk("R6", "ihs held after failover", int'(osc_en[0]), 1);
        // R9 failure in the clear cycle keeps the flag
        css_wr = 1'b1; css_wdata = 1'b1; step(1); css_wr = 1'b0;
        step(TMO - 1);
        fail_clr = 1'b1; step(1); fail_clr = 1'b0;
        chk("R9", "set wins over clear", int'(fail_flag), 1);
        chk("R8", "monitor off again", int'(css_on), 0);
        pulse_clr();
        chk("R9", "flag cleared", int'(fail_flag), 0);
        // Switch to internal low-speed
        osc_rdy[2] = 1'b1;
        wr_en(4'b0100);
        chk("R6", "ihs held while in use", int'(osc_en), 4'b0101);
        wr_sel(3'd3);
        step(1);
        chk("R3", "switched to int-ls", int'(src_status), 3);
        wr_en(4'b0110);
        chk("R5", "enables after write", int'(osc_en), 4'b0110);
        // R5/R6 low-power entry
        lp_mode = 1'b1;
        step(2);
        chk("R5", "ehs cleared on lp entry", int'(osc_en[1]), 0);
        chk("R6", "ihs low in lp", int'(osc_en[0]), 0);
        // R4 low-power exit
        lp_mode = 1'b0;
        step(1);
        chk("R4", "sel after exit", int'(sel_q), 0);
        chk("R4", "status after exit", int'(src_status), 0);
        chk("R4", "ihs on after exit", int'(osc_en[0]), 1);
        // External low-speed, lock check
        osc_rdy[3] = 1'b1;
        wr_en(4'b1000);
        wr_sel(3'd4);
        step(1);
        chk("R3", "switched to ext-ls", int'(src_status), 4);
        wr_en(4'b0000);
        chk("R5", "ext-ls enable kept", int'(osc_en), 4'b1000);
        wr_sel(3'd6);
        chk("R1", "code 6 ignored", int'(sel_q), 4);
        step(3);
        finish_run();
    end
endmodule